// File: doc/BRIEF.md
# Multicore Private Region Decoder

This block sits at the front of an 8 KB private peripheral window that serves a cluster of up to four cores. Each request carries a byte offset into the window and the index of the core that issued it. The block serves a small set of snoop-control registers itself. Every other offset is steered to one of four kinds of subordinate window: the per-core interrupt CPU interfaces, the per-core timers, the per-core watchdogs, and the shared interrupt distributor. For these it raises exactly one select line and passes on an offset that is local to the chosen window.

Some windows are "current core" aliases. These resolve through the requester index to that core's own select line, so software reaches its own interface at one fixed address. A per-core window that names a core the cluster does not have is a decode error. The block answers it locally with zero and flags it. The block also packs each core's timer and watchdog interrupt lines into that core's bank of 32 private interrupt lines, at fixed positions.

Top module: `mc_priv_decoder`

## Requirements
- R1: The control register at offset 0x000 resets to 0. A write stores only bit 0 of the write data, and a read returns that bit with all other bits zero.
- R2: The read-only word at offset 0x004 reads as a presence mask in bits starting at bit 4, with one set bit per configured core. It is ORed with the core count minus one in the low bits: 0x10 for one core, 0x31 for two cores.
- R3: Offset 0x008 always reads zero. Offset 0x00C reads zero, and a write to it is accepted without error and changes no register.
- R4: Any other offset in 0x000–0x0FF reads zero and ignores writes. So does a write to 0x004 or 0x008. Each of these raises guest_err together with the response.
- R5: A locally served access (control area or decode error) gets resp_valid high for exactly the one cycle after the request cycle. A forwarded access gets no local response.
- R6: Offset 0x100–0x1FF selects the interrupt CPU interface of the requesting core. Offset 0x200 + k·0x100 selects that of core k. The local offset is address bits 7:0.
- R7: Block j at 0x600 + j·0x100 holds a timer at block offsets 0x00–0x1F and a watchdog at 0x20–0x3F. Block j = 0 is the requesting core, and j = k+1 is core k. The local offset is address bits 4:0.
- R8: Offsets 0x1000–0x1FFF select the distributor, with local offset equal to the address minus 0x1000.
- R9: These are all decode errors: a per-core window whose core index is at or beyond the configured count, an alias used by a requester outside that count, block offsets 0x40–0xFF of a timer block, and 0xB00–0xFFF. A decode error raises no select, reads zero, and raises guest_err.
- R10: For core k, private interrupt line k·32+29 follows its timer interrupt and line k·32+30 follows its watchdog interrupt. All other private lines stay low.
- R11: The select outputs are combinational in the request cycle, at most one of them is high, and none is high without req_valid.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Access request present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 13 | Byte offset into the 8 KB window |
| req_wdata | input | 32 | Write data |
| req_core | input | 2 | Index of the requesting core |
| resp_valid | output | 1 | Local response strobe |
| resp_rdata | output | 32 | Local read data |
| guest_err | output | 1 | Bad local access, valid with resp_valid |
| cpuif_sel | output | NCORES | Interrupt CPU interface select per core |
| timer_sel | output | NCORES | Timer select per core |
| wdog_sel | output | NCORES | Watchdog select per core |
| dist_sel | output | 1 | Distributor select |
| sub_offset | output | 12 | Offset local to the selected window |
| timer_irq | input | NCORES | Timer interrupt per core |
| wdog_irq | input | NCORES | Watchdog interrupt per core |
| ppi_out | output | 32·NCORES | Private interrupt lines, 32 per core |

## Verification
Some properties are checked on every cycle: that the selects are mutually exclusive and gated by req_valid, that a local response follows only a request cycle, that guest_err never appears without a response, that the control bit moves only after a write, and that the unused private interrupt lines stay low. The scenarios alone show the address map itself. They check alias resolution for different requesters, the window boundaries and local offsets, the computed configuration word, and which out-of-range cores and sub-blocks become decode errors. They also check that ignored writes leave the control register unchanged.

// File: rtl/mc_priv_decoder.sv
module mc_priv_decoder #(
  parameter int NCORES = 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 req_valid,
  input  logic                 req_write,
  input  logic [12:0]          req_addr,
  input  logic [31:0]          req_wdata,
  input  logic [1:0]           req_core,
  output logic                 resp_valid,
  output logic [31:0]          resp_rdata,
  output logic                 guest_err,
  output logic [NCORES-1:0]    cpuif_sel,
  output logic [NCORES-1:0]    timer_sel,
  output logic [NCORES-1:0]    wdog_sel,
  output logic                 dist_sel,
  output logic [11:0]          sub_offset,
  input  logic [NCORES-1:0]    timer_irq,
  input  logic [NCORES-1:0]    wdog_irq,
  output logic [32*NCORES-1:0] ppi_out
);
  localparam logic [2:0]  NC3    = 3'(NCORES);
  localparam logic [31:0] CFG_WD = (((32'd1 << NCORES) - 32'd1) << 4) | 32'(NCORES - 1);

  logic       ctrl_q;
  logic [3:0] blk;
  logic       is_scu, is_dist, is_cpu, is_tw;
  logic [2:0] j, idx;
  logic       idx_ok, hit_cpu, hit_tmr, hit_wd, dec_err, local_acc;
  logic [31:0] scu_rd;
  logic       scu_bad;

  assign blk     = req_addr[11:8];
  assign is_dist = req_addr[12];
  assign is_scu  = !req_addr[12] && blk == 4'd0;
  assign is_cpu  = !req_addr[12] && blk >= 4'd1 && blk <= 4'd5;
  assign is_tw   = !req_addr[12] && blk >= 4'd6 && blk <= 4'd10;

  always_comb begin
    logic [3:0] jj;
    jj  = is_cpu ? blk - 4'd1 : blk - 4'd6;
    j   = jj[2:0];
    idx = (j == 3'd0) ? {1'b0, req_core} : j - 3'd1;
  end

  assign idx_ok    = idx < NC3;
  assign hit_cpu   = req_valid && is_cpu && idx_ok;
  assign hit_tmr   = req_valid && is_tw && idx_ok && req_addr[7:5] == 3'd0;
  assign hit_wd    = req_valid && is_tw && idx_ok && req_addr[7:5] == 3'd1;
  assign dist_sel  = req_valid && is_dist;
  assign dec_err   = req_valid && !is_scu && !is_dist && !(hit_cpu || hit_tmr || hit_wd);
  assign local_acc = (req_valid && is_scu) || dec_err;

  generate
    for (genvar k = 0; k < NCORES; k++) begin : g_core
      assign cpuif_sel[k] = hit_cpu && idx == 3'(k);
      assign timer_sel[k] = hit_tmr && idx == 3'(k);
      assign wdog_sel[k]  = hit_wd  && idx == 3'(k);
      always_comb begin
        ppi_out[32*k +: 32]     = '0;
        ppi_out[32*k + 29]      = timer_irq[k];
        ppi_out[32*k + 30]      = wdog_irq[k];
      end
      always_comb begin
        if (rst_n) assert_ppi_quiet_R10: assert ((ppi_out[32*k +: 32] & ~32'h6000_0000) == 32'd0);
      end
    end
  endgenerate

  always_comb begin
    if (is_dist)     sub_offset = req_addr[11:0];
    else if (is_tw)  sub_offset = {7'd0, req_addr[4:0]};
    else             sub_offset = {4'd0, req_addr[7:0]};
  end

  always_comb begin
    scu_rd  = 32'd0;
    scu_bad = 1'b0;
    case (req_addr[7:0])
      8'h00:   scu_rd = {31'd0, ctrl_q};
      8'h04: begin scu_rd = CFG_WD; scu_bad = req_write; end
      8'h08:   scu_bad = req_write;
      8'h0C:   scu_bad = 1'b0;
      default: scu_bad = 1'b1;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_q     <= 1'b0;
      resp_valid <= 1'b0;
      resp_rdata <= 32'd0;
      guest_err  <= 1'b0;
    end else begin
      resp_valid <= local_acc;
      resp_rdata <= (local_acc && is_scu && !req_write) ? scu_rd : 32'd0;
      guest_err  <= dec_err || (req_valid && is_scu && scu_bad);
      if (req_valid && req_write && is_scu && req_addr[7:0] == 8'h00)
        ctrl_q <= req_wdata[0];
    end
  end

  assert_sel_onehot_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({cpuif_sel, timer_sel, wdog_sel, dist_sel}));
  assert_sel_needs_req_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |-> ({cpuif_sel, timer_sel, wdog_sel, dist_sel} == '0));
  assert_resp_after_req_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(resp_valid) |-> $past(req_valid));
  assert_err_with_resp_R4: assert property (@(posedge clk) disable iff (!rst_n)
    guest_err |-> resp_valid);
  assert_ctrl_only_on_write_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_valid && req_write) |=> $stable(ctrl_q));
  assert_err_no_data_R9: assert property (@(posedge clk) disable iff (!rst_n)
    dec_err |=> resp_rdata == 32'd0);
endmodule

// File: tb/mc_priv_decoder_tb.sv
`timescale 1ns/1ps
module mc_priv_decoder_tb_top;
  localparam int NC = 2;
  logic clk = 0, rst_n = 0;
  logic req_valid = 0, req_write = 0;
  logic [12:0] req_addr = 0;
  logic [31:0] req_wdata = 0;
  logic [1:0] req_core = 0;
  logic resp_valid, guest_err, dist_sel;
  logic [31:0] resp_rdata;
  logic [NC-1:0] cpuif_sel, timer_sel, wdog_sel;
  logic [11:0] sub_offset;
  logic [NC-1:0] timer_irq = 0, wdog_irq = 0;
  logic [32*NC-1:0] ppi_out;
  int checks = 0, errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  mc_priv_decoder #(.NCORES(NC)) dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_core(req_core),
    .resp_valid(resp_valid), .resp_rdata(resp_rdata), .guest_err(guest_err),
    .cpuif_sel(cpuif_sel), .timer_sel(timer_sel), .wdog_sel(wdog_sel),
    .dist_sel(dist_sel), .sub_offset(sub_offset),
    .timer_irq(timer_irq), .wdog_irq(wdog_irq), .ppi_out(ppi_out));

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic local_acc(string req, logic [12:0] a, logic wr, logic [31:0] wd,
                           logic [31:0] exp_rd, logic exp_err);
    @(negedge clk);
    req_valid = 1; req_write = wr; req_addr = a; req_wdata = wd; req_core = 0;
    #1 check({req, " no select"}, {cpuif_sel, timer_sel, wdog_sel, dist_sel}, 0);
    @(negedge clk);
    check({req, " resp_valid R5"}, resp_valid, 1);
    check({req, " rdata"}, resp_rdata, exp_rd);
    check({req, " guest_err"}, guest_err, exp_err);
    req_valid = 0;
    @(negedge clk);
    check({req, " resp single cycle R5"}, resp_valid, 0);
  endtask

  task automatic fwd_acc(string req, logic [12:0] a, logic [1:0] core,
                         logic [NC-1:0] ec, logic [NC-1:0] et, logic [NC-1:0] ew,
                         logic ed, logic [11:0] eo);
    @(negedge clk);
    req_valid = 1; req_write = 0; req_addr = a; req_core = core;
    #1 check({req, " selects"}, {cpuif_sel, timer_sel, wdog_sel, dist_sel}, {ec, et, ew, ed});
    check({req, " offset"}, sub_offset, eo);
    @(negedge clk);
    check({req, " no local resp R5"}, resp_valid, 0);
    req_valid = 0;
  endtask

  task automatic t_reset;
    check("R1 reset resp_valid", resp_valid, 0);
    local_acc("R1 ctrl reset value", 13'h000, 0, 0, 32'h0, 0);
  endtask

  task automatic t_ctrl;
    local_acc("R1 write ctrl", 13'h000, 1, 32'hFFFF_FFFF, 0, 0);
    local_acc("R1 ctrl readback", 13'h000, 0, 0, 32'h1, 0);
    local_acc("R1 write ctrl even", 13'h000, 1, 32'hFFFF_FFFE, 0, 0);
    local_acc("R1 ctrl cleared", 13'h000, 0, 0, 32'h0, 0);
    local_acc("R1 set again", 13'h000, 1, 32'h1, 0, 0);
  endtask

  task automatic t_cfg_status;
    local_acc("R2 config word", 13'h004, 0, 0, 32'h31, 0);
    local_acc("R3 status reads zero", 13'h008, 0, 0, 0, 0);
    local_acc("R3 invalidate reads zero", 13'h00C, 0, 0, 0, 0);
    local_acc("R3 invalidate write", 13'h00C, 1, 32'h0, 0, 0);
    local_acc("R3 ctrl unchanged", 13'h000, 0, 0, 32'h1, 0);
  endtask

  task automatic t_bad_scu;
    local_acc("R4 bad read", 13'h010, 0, 0, 0, 1);
    local_acc("R4 bad write", 13'h0FC, 1, 32'h0, 0, 1);
    local_acc("R4 write config", 13'h004, 1, 32'h0, 0, 1);
    local_acc("R4 write status", 13'h008, 1, 32'h0, 0, 1);
    local_acc("R4 config unchanged", 13'h004, 0, 0, 32'h31, 0);
    local_acc("R4 ctrl unchanged", 13'h000, 0, 0, 32'h1, 0);
  endtask

  task automatic t_cpuif;
    fwd_acc("R6 alias core0", 13'h104, 0, 2'b01, 0, 0, 0, 12'h004);
    fwd_acc("R6 alias core1", 13'h1F0, 1, 2'b10, 0, 0, 0, 12'h0F0);
    fwd_acc("R6 core0 window", 13'h208, 1, 2'b01, 0, 0, 0, 12'h008);
    fwd_acc("R6 core1 window", 13'h3FC, 0, 2'b10, 0, 0, 0, 12'h0FC);
  endtask

  task automatic t_timer;
    fwd_acc("R7 timer alias core1", 13'h60C, 1, 0, 2'b10, 0, 0, 12'h00C);
    fwd_acc("R7 wdog alias core0", 13'h624, 0, 0, 0, 2'b01, 0, 12'h004);
    fwd_acc("R7 timer core0", 13'h71F, 1, 0, 2'b01, 0, 0, 12'h01F);
    fwd_acc("R7 wdog core1", 13'h83C, 0, 0, 0, 2'b10, 0, 12'h01C);
  endtask

  task automatic t_dist;
    fwd_acc("R8 dist low", 13'h1000, 0, 0, 0, 0, 1, 12'h000);
    fwd_acc("R8 dist high", 13'h1FFC, 1, 0, 0, 0, 1, 12'hFFC);
  endtask

  task automatic t_decerr;
    local_acc("R9 cpuif core2", 13'h400, 0, 0, 0, 1);
    local_acc("R9 timer core3", 13'hA00, 1, 32'h0, 0, 1);
    local_acc("R9 timer block gap", 13'h640, 0, 0, 0, 1);
    local_acc("R9 unused area", 13'hC00, 0, 0, 0, 1);
    @(negedge clk);
    req_valid = 1; req_write = 0; req_addr = 13'h100; req_core = 3;
    #1 check("R9 alias bad core no select", {cpuif_sel, timer_sel, wdog_sel, dist_sel}, 0);
    @(negedge clk);
    check("R9 alias bad core err", {resp_valid, guest_err, resp_rdata}, {2'b11, 32'h0});
    req_valid = 0;
    local_acc("R9 ctrl unchanged", 13'h000, 0, 0, 32'h1, 0);
  endtask

  task automatic t_ppi;
    @(negedge clk);
    timer_irq = 2'b01; wdog_irq = 2'b10;
    #1 check("R10 ppi pattern a", ppi_out, {32'h4000_0000, 32'h2000_0000});
    timer_irq = 2'b10; wdog_irq = 2'b11;
    #1 check("R10 ppi pattern b", ppi_out, {32'h6000_0000, 32'h4000_0000});
    timer_irq = 0; wdog_irq = 0;
    #1 check("R10 ppi idle", ppi_out, 64'h0);
  endtask

  task automatic t_idle;
    @(negedge clk);
    req_valid = 0; req_addr = 13'h1000;
    #1 check("R11 no select idle", {cpuif_sel, timer_sel, wdog_sel, dist_sel}, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_ctrl();
    t_cfg_status();
    t_bad_scu();
    t_cpuif();
    t_timer();
    t_dist();
    t_decerr();
    t_ppi();
    t_idle();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule